// File: doc/BRIEF.md
# Two-Wire Master Byte Engine

This block drives a two-wire serial bus (I2C style) as its only master. It works one bus event at a time. Software picks an event through a control write: a START (or a repeated START), one byte, or a STOP. The engine carries that event out on open-drain SCL and SDA pull-down outputs. When a START or a byte has finished, the engine sets a completion flag and publishes a status code. It then parks the bus with SCL held low until software tells it what comes next. An interrupt request comes from the flag, gated by a local enable and by a global enable.

The first byte after any START is taken as the address. If the slave acknowledges an address whose bit 0 is 1, every following byte until the next START or STOP is received rather than sent. A received byte is shifted in MSB first, and the master answers it in the ninth bit with an ACK or a NACK, as chosen by a control bit. An 8-bit rate value N sets the length of every SCL half-period to N+1 system clocks. The register-style pins are plain strobes, so there is no valid/ready stream and no back-pressure: software paces every transfer through the flag.

Top module: `twi_byte_master`

## Requirements
- R1: After reset, the data readback is 0xFF, the flag is 0, the status is 0, the irq output is 0, and both SCL and SDA are released (neither pull output is active).
- R2: A control write with the enable, start and flag-clear bits set produces a START. From an idle bus, SDA falls while SCL is high, then SCL goes low. From a parked bus, SDA is first released, then SCL is released, and then the same falling edge follows. When the START finishes, the flag is set and the status reads 1.
- R3: While the flag is set, SCL is held low, and SDA, the status and the bus stay unchanged. Nothing happens on the bus until a control write arrives with the enable and flag-clear bits both at 1. That write clears the flag.
- R4: A data write is accepted only while the flag is 1. A data write while the flag is 0 leaves the data readback unchanged.
- R5: A byte transfer sends the data register MSB first. SDA changes only while SCL is low, except during START and STOP. The master releases SDA in the ninth bit and samples it, where low means ACK and high means NACK. Afterwards, the data readback holds the byte seen on the bus.
- R6: The first byte after a START reports status 2 when ACKed and 3 when NACKed. An ACKed address with bit 0 set to 1 switches the following bytes to receive.
- R7: A data byte sent after a write address reports status 4 when ACKed and 5 when NACKed.
- R8: In receive, the engine releases SDA for eight bits and stores them MSB first in the data readback. It reports status 6. In the ninth bit it pulls SDA low if the ack control bit was 1 at the clear write, and leaves SDA released otherwise.
- R9: A control write with the stop and flag-clear bits set (start clear) on a parked bus first pulls SDA low. It then releases SCL, then releases SDA while SCL is high. The bus ends with both lines released, the flag clear and the status 0.
- R10: irq is 1 exactly when the flag, the stored irq-enable bit and the global_irq_en input are all 1.
- R11: With rate value N of 1 or more, every SCL high half and every SCL low half between bits lasts N+1 clocks. With N of 0, a low half between bits lasts 2 clocks.
- R12: When start and stop are both set, start wins. A control write with the enable bit 0 releases both lines at once and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| global_irq_en | input | 1 | Global interrupt enable |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Byte to send next |
| data_rdata | output | 8 | Last byte seen on the bus |
| rate_wr | input | 1 | Rate register write strobe |
| rate_wdata | input | 8 | Rate value N (half period = N+1 clocks) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_start | input | 1 | Request a START |
| ctrl_stop | input | 1 | Request a STOP |
| ctrl_enable | input | 1 | Engine enable |
| ctrl_irq_en | input | 1 | Local interrupt enable |
| ctrl_ack | input | 1 | ACK received bytes |
| ctrl_flag_clr | input | 1 | Clear the flag and launch the chosen operation |
| done_flag | output | 1 | Completion flag |
| status_code | output | 3 | Result of the last event |
| irq | output | 1 | Interrupt request |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
Suppose the bit counter or the phase state is wrong. The bus monitor then counts a number of SCL rising edges other than nine, or sees an SDA edge while SCL is high, and both errors show within one byte time. If the flag or the status logic is wrong, the bench sees a stuck or early flag or a wrong code at the very next event. If the address or receive mode is tracked wrongly, the error appears at the following byte as a wrong status, or as SDA driven when it should be released. A divider error shows in the first half-period the bench measures.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_NONE      = 3'd0,
    ST_START     = 3'd1,
    ST_ADDR_ACK  = 3'd2,
    ST_ADDR_NACK = 3'd3,
    ST_DATA_ACK  = 3'd4,
    ST_DATA_NACK = 3'd5,
    ST_DATA_RX   = 3'd6
  } twi_status_e;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_XFER  = 2'd2
  } twi_cmd_e;
endpackage

// File: rtl/twi_rate_div.sv
module twi_rate_div #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] limit,
  output logic          tick
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= limit;
    else if (cnt_q == '0)  cnt_q <= limit;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/twi_bit_fsm.sv
module twi_bit_fsm
  import twi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  twi_cmd_e      cmd,
  input  logic          rx,
  input  logic          ack_out,
  input  logic [DW-1:0] tx_byte,
  input  logic          tick,
  input  logic          sda_in,
  output logic          busy,
  output logic          done,
  output logic          ack_now,
  output logic [DW-1:0] rx_byte,
  output logic          scl_low,
  output logic          sda_low,
  output logic          cond_phase
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_RS_UP, S_ST_FALL, S_ST_LOW,
    S_BIT_LOW, S_BIT_HIGH, S_SP_UP, S_SP_REL
  } phase_e;

  phase_e        st_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          fresh_q, rx_q, ackm_q, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; sh_q <= '0; cnt_q <= '0; fresh_q <= 1'b0;
      rx_q <= 1'b0; ackm_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else if (clr) begin
      st_q <= S_IDLE; fresh_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (go && cmd == CMD_START) st_q <= S_ST_FALL;
        S_HOLD: if (go) begin
          case (cmd)
            CMD_START: begin sda_q <= 1'b0; st_q <= S_RS_UP; end
            CMD_STOP:  begin sda_q <= 1'b1; st_q <= S_SP_UP; end
            default: begin
              sh_q <= tx_byte; cnt_q <= '0; fresh_q <= 1'b1;
              rx_q <= rx; ackm_q <= ack_out; st_q <= S_BIT_LOW;
            end
          endcase
        end
        S_RS_UP:   if (tick) begin scl_q <= 1'b0; st_q <= S_ST_FALL; end
        S_ST_FALL: if (tick) begin sda_q <= 1'b1; st_q <= S_ST_LOW; end
        S_ST_LOW:  if (tick) begin scl_q <= 1'b1; st_q <= S_HOLD; end
        S_BIT_LOW: begin
          if (fresh_q) begin
            fresh_q <= 1'b0;
            if (cnt_q == LAST) sda_q <= rx_q & ackm_q;
            else               sda_q <= !rx_q & !sh_q[DW-1];
          end else if (tick) begin
            scl_q <= 1'b0; st_q <= S_BIT_HIGH;
          end
        end
        S_BIT_HIGH: if (tick) begin
          scl_q <= 1'b1;
          if (cnt_q == LAST) st_q <= S_HOLD;
          else begin
            sh_q <= {sh_q[DW-2:0], sda_in};
            cnt_q <= cnt_q + 1'b1; fresh_q <= 1'b1; st_q <= S_BIT_LOW;
          end
        end
        S_SP_UP:  if (tick) begin scl_q <= 1'b0; st_q <= S_SP_REL; end
        S_SP_REL: if (tick) begin sda_q <= 1'b0; st_q <= S_IDLE; end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != S_IDLE) && (st_q != S_HOLD);
  assign done       = !clr && tick &&
                      ((st_q == S_ST_LOW) || (st_q == S_BIT_HIGH && cnt_q == LAST));
  assign ack_now    = !sda_in;
  assign rx_byte    = sh_q;
  assign scl_low    = scl_q;
  assign sda_low    = sda_q;
  assign cond_phase = (st_q == S_ST_FALL) || (st_q == S_SP_REL);
endmodule

// File: rtl/twi_byte_master.sv
module twi_byte_master
  import twi_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          global_irq_en,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  output logic [DW-1:0] data_rdata,
  input  logic          rate_wr,
  input  logic [RW-1:0] rate_wdata,
  input  logic          ctrl_wr,
  input  logic          ctrl_start,
  input  logic          ctrl_stop,
  input  logic          ctrl_enable,
  input  logic          ctrl_irq_en,
  input  logic          ctrl_ack,
  input  logic          ctrl_flag_clr,
  output logic          done_flag,
  output logic [2:0]    status_code,
  output logic          irq,
  output logic          scl_pull,
  output logic          sda_pull,
  input  logic          sda_in
);
  logic [DW-1:0] data_q, rx_byte;
  logic [RW-1:0] rate_q;
  logic          en_q, ie_q, ack_q, flag_q, addr_next_q, rd_mode_q;
  twi_status_e   status_q;
  twi_cmd_e      cmd_q, cmd_sel;
  logic          busy, tick, done, ack_now, cond_phase, clr, go;

  assign clr     = ctrl_wr ? !ctrl_enable : !en_q;
  assign go      = ctrl_wr && ctrl_enable && ctrl_flag_clr && !busy;
  assign cmd_sel = ctrl_start ? CMD_START : (ctrl_stop ? CMD_STOP : CMD_XFER);

  twi_rate_div #(.RW(RW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .limit(rate_q), .tick(tick)
  );

  twi_bit_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(go), .cmd(cmd_sel),
    .rx(rd_mode_q && !addr_next_q), .ack_out(ctrl_ack), .tx_byte(data_q),
    .tick(tick), .sda_in(sda_in), .busy(busy), .done(done),
    .ack_now(ack_now), .rx_byte(rx_byte), .scl_low(scl_pull),
    .sda_low(sda_pull), .cond_phase(cond_phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '1; rate_q <= '0; en_q <= 1'b0; ie_q <= 1'b0; ack_q <= 1'b0;
      flag_q <= 1'b0; status_q <= ST_NONE; addr_next_q <= 1'b0;
      rd_mode_q <= 1'b0; cmd_q <= CMD_STOP;
    end else begin
      if (rate_wr) rate_q <= rate_wdata;
      if (ctrl_wr) begin
        en_q <= ctrl_enable; ie_q <= ctrl_irq_en; ack_q <= ctrl_ack;
      end
      if (clr || (ctrl_wr && ctrl_flag_clr)) flag_q <= 1'b0;
      else if (done)                          flag_q <= 1'b1;
      if (data_wr && flag_q) data_q <= data_wdata;
      if (go) begin
        cmd_q <= cmd_sel;
        if (cmd_sel == CMD_STOP) begin
          status_q <= ST_NONE; addr_next_q <= 1'b0; rd_mode_q <= 1'b0;
        end
      end
      if (done) begin
        data_q <= rx_byte;
        if (cmd_q == CMD_START) begin
          status_q <= ST_START; addr_next_q <= 1'b1; rd_mode_q <= 1'b0;
        end else if (addr_next_q) begin
          status_q    <= ack_now ? ST_ADDR_ACK : ST_ADDR_NACK;
          addr_next_q <= 1'b0;
          rd_mode_q   <= ack_now & rx_byte[0];
        end else if (rd_mode_q) begin
          status_q <= ST_DATA_RX;
        end else begin
          status_q <= ack_now ? ST_DATA_ACK : ST_DATA_NACK;
        end
      end
    end
  end

  assign data_rdata  = data_q;
  assign done_flag   = flag_q;
  assign status_code = status_q;
  assign irq         = flag_q & ie_q & global_irq_en;
endmodule

// File: rtl/twi_byte_master_chk.sv
module twi_byte_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_flag,
  input logic [2:0]    status_code,
  input logic          scl_pull,
  input logic          sda_pull,
  input logic          data_wr,
  input logic [DW-1:0] data_rdata,
  input logic          irq,
  input logic          busy,
  input logic          cond_phase,
  input logic          en
);
  AST_HOLD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && $past(done_flag)) |-> (scl_pull && $stable(sda_pull) && $stable(status_code))); // R3

  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !done_flag && !busy) |=> $stable(data_rdata)); // R4

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && !$past(scl_pull) && $past(en) && (sda_pull != $past(sda_pull))) |-> $past(cond_phase)); // R5

  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag); // R10

  AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> (status_code != 3'd0 && status_code != 3'd7)); // R6
endmodule

bind twi_byte_master twi_byte_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_flag(done_flag), .status_code(status_code),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .data_wr(data_wr),
  .data_rdata(data_rdata), .irq(irq), .busy(busy), .cond_phase(cond_phase),
  .en(en_q)
);

// File: tb/test_twi_byte_master.sv
module test_twi_byte_master;
  logic clk = 1'b0, rst_n = 1'b0, gie = 1'b0;
  logic data_wr = 1'b0, rate_wr = 1'b0, ctrl_wr = 1'b0;
  logic [7:0] data_wdata = '0, rate_wdata = '0, data_rdata;
  logic c_start = 0, c_stop = 0, c_en = 0, c_ie = 0, c_ack = 0, c_clr = 0;
  logic done_flag, irq, scl_pull, sda_pull, slave_low = 1'b0;
  logic [2:0] status_code;
  wire scl_line = !scl_pull;
  wire sda_line = !(sda_pull || slave_low);

  int n_chk = 0, n_fail = 0, n_start = 0, n_stop = 0, mon_n = 0, cur_n = 0;
  logic [8:0] mon_sh = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  twi_byte_master i_twi_byte_master (
    .clk(clk), .rst_n(rst_n), .global_irq_en(gie), .data_wr(data_wr),
    .data_wdata(data_wdata), .data_rdata(data_rdata), .rate_wr(rate_wr),
    .rate_wdata(rate_wdata), .ctrl_wr(ctrl_wr), .ctrl_start(c_start),
    .ctrl_stop(c_stop), .ctrl_enable(c_en), .ctrl_irq_en(c_ie),
    .ctrl_ack(c_ack), .ctrl_flag_clr(c_clr), .done_flag(done_flag),
    .status_code(status_code), .irq(irq), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .sda_in(sda_line)
  );

  always @(posedge scl_line) begin mon_sh = {mon_sh[7:0], sda_line}; mon_n++; end
  always @(negedge sda_line) if (scl_line === 1'b1) n_start++;
  always @(posedge sda_line) if (scl_line === 1'b1) n_stop++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctrl(input bit en, input bit st, input bit sp, input bit ack, input bit clr);
    @(negedge clk);
    ctrl_wr = 1; c_en = en; c_start = st; c_stop = sp; c_ie = 1'b0; c_ack = ack; c_clr = clr;
    @(negedge clk);
    ctrl_wr = 0; c_start = 0; c_stop = 0; c_clr = 0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_wdata = v;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic wr_rate(input int n);
    cur_n = n;
    @(negedge clk); rate_wr = 1; rate_wdata = 8'(n);
    @(negedge clk); rate_wr = 0;
  endtask

  task automatic wait_flag(input string tag);
    int n = 0;
    while (!done_flag && n < 20000) begin @(negedge clk); n++; end
    chk(tag, done_flag, 1);
  endtask

  function automatic int exp_st(input bit is_addr, input bit rx, input bit ack);
    if (is_addr) return ack ? 2 : 3;
    if (rx) return 6;
    return ack ? 4 : 5;
  endfunction

  task automatic slave_byte(input bit rx, input logic [7:0] v, input bit ack);
    if (rx) begin
      slave_low = !v[7];
      for (int k = 6; k >= 0; k--) begin @(negedge scl_line); slave_low = !v[k]; end
      @(negedge scl_line); slave_low = 0;
      @(negedge scl_line);
    end else begin
      repeat (8) @(negedge scl_line);
      slave_low = ack;
      @(negedge scl_line); slave_low = 0;
    end
  endtask

  task automatic do_start(input string tag);
    int s0 = n_start;
    ctrl(1, 1, 0, 0, 1);
    wait_flag({tag, " R2 flag"});
    chk({tag, " R2 status"}, status_code, 1);
    chk({tag, " R2 start cond"}, n_start - s0, 1);
  endtask

  task automatic do_byte(input string tag, input bit is_addr, input bit rx,
                         input logic [7:0] v, input bit ack);
    if (!rx) wr_data(v);
    mon_n = 0;
    fork
      ctrl(1, 0, 0, rx ? ack : 1'b0, 1);
      slave_byte(rx, v, ack);
    join
    wait_flag({tag, " flag"});
    chk({tag, is_addr ? " R6 status" : (rx ? " R8 status" : " R7 status")},
        status_code, exp_st(is_addr, rx, ack));
    chk({tag, " R5 bit count"}, mon_n, 9);
    if (rx) begin
      chk({tag, " R8 rx data"}, data_rdata, v);
      chk({tag, " R8 master ack bit"}, mon_sh[0], !ack);
    end else begin
      chk({tag, " R5 bus byte"}, mon_sh[8:1], v);
      chk({tag, " R5 readback"}, data_rdata, v);
    end
  endtask

  task automatic do_stop(input string tag);
    int p0 = n_stop;
    ctrl(1, 0, 1, 0, 1);
    repeat (2 * (cur_n + 1) + 6) @(negedge clk);
    chk({tag, " R9 stop cond"}, n_stop - p0, 1);
    chk({tag, " R9 lines"}, {scl_line, sda_line}, 2'b11);
    chk({tag, " R9 flag"}, done_flag, 0);
    chk({tag, " R9 status"}, status_code, 0);
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (!scl_line) @(negedge clk);
    while (scl_line) begin hi++; @(negedge clk); end
    while (!scl_line) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=hang expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, lo, mv, pn;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 readback", data_rdata, 8'hFF);
    chk("R1 flag", done_flag, 0);
    chk("R1 status", status_code, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_pull, sda_pull}, 2'b00);

    wr_data(8'h3C);
    chk("R4 write ignored", data_rdata, 8'hFF);

    wr_rate(3);
    do_start("first");
    mv = mon_n;
    repeat (40) @(negedge clk);
    chk("R3 flag held", done_flag, 1);
    chk("R3 scl held low", scl_line, 0);
    chk("R3 no bus edges", mon_n, mv);

    do_byte("wr addr", 1, 0, 8'hA4, 1);
    do_byte("data ack", 0, 0, 8'h5A, 1);
    do_byte("data nack", 0, 0, 8'h81, 0);

    pn = n_stop;
    ctrl(1, 1, 1, 0, 1);
    wait_flag("R12 both flag");
    chk("R12 start wins status", status_code, 1);
    chk("R12 no stop", n_stop - pn, 0);

    do_byte("rd addr", 1, 0, 8'hA5, 1);
    do_byte("rx ack", 0, 1, 8'hC3, 1);
    do_byte("rx nack", 0, 1, 8'h3E, 0);
    do_stop("stop1");

    do_start("nack addr start");
    do_byte("nack addr", 1, 0, 8'h20, 0);

    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 2; e++) begin
        gie = g[0];
        @(negedge clk); ctrl_wr = 1; c_en = 1; c_ie = e[0]; c_clr = 0;
        @(negedge clk); ctrl_wr = 0;
        chk($sformatf("R10 irq g=%0d e=%0d", g, e), irq, g & e);
      end
    end
    gie = 0;

    ctrl(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R12 disable lines", {scl_line, sda_line}, 2'b11);
    chk("R12 disable flag", done_flag, 0);

    for (int t = 0; t < 4; t++) begin
      int n = (t == 0) ? 1 : int'($urandom_range(2, 12));
      wr_rate(n);
      do_start("rate start");
      wr_data(8'hB6);
      fork
        ctrl(1, 0, 0, 0, 1);
        slave_byte(0, 8'hB6, 1);
        measure(hi, lo);
      join
      wait_flag("rate flag");
      chk($sformatf("R11 high n=%0d", n), hi, n + 1);
      chk($sformatf("R11 low n=%0d", n), lo, n + 1);
      do_stop("rate stop");
    end

    for (int t = 0; t < 16; t++) begin
      bit rw = $urandom_range(0, 1);
      bit aa = ($urandom_range(0, 3) != 0);
      logic [7:0] ad = {7'($urandom_range(0, 127)), rw};
      wr_rate($urandom_range(0, 6));
      do_start("rand start");
      do_byte("rand addr", 1, 0, ad, aa);
      if (aa) begin
        int nb = $urandom_range(1, 3);
        for (int b = 0; b < nb; b++)
          do_byte(rw ? "rand rx" : "rand tx", 0, rw, 8'($urandom_range(0, 255)),
                  $urandom_range(0, 1));
      end
      do_stop("rand stop");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule